// File: doc/BRIEF.md
# MMU Control Register Loader

This block carries out the register-move side of a paged memory management unit's control instructions. A caller presents a 16-bit command extension word with an operand address. The block decodes the word, fetches the register image from memory as a series of 16-bit reads, and assembles 32-bit or 64-bit values from them. With these it loads one of four registers: the translation control word, the supervisor root pointer, the CPU root pointer or the 16-bit MMU status register. One form stores the status register to memory with a single 16-bit write instead. Command patterns that the block does not carry out are reported back. The caller sees a one-cycle done pulse with a status code, and no register changes.

Bit 31 of the translation control word drives a translation-enable output. The address translator reads the loaded root pointers and control word directly from the register outputs.

The sequencer has four named states. `S_IDLE` accepts a command and moves to `S_READ`, `S_WRITE` or `S_FINISH`, according to the decoded operation. `S_READ` loops, issuing one halfword request per beat, and moves to `S_FINISH` when the last read handshake completes. `S_WRITE` moves to `S_FINISH` when its single handshake completes. `S_FINISH` raises `done` for one cycle and always returns to `S_IDLE`.

Top module: `mmu_ctl_loader`

## Requirements
- R1: A command word with (word & 0xFDE0) == 0x2000 is a load-entry request. It finishes with status 1 (unsupported), makes no memory access and changes no register.
- R2: A word that fails the R1 test but has (word & 0xE200) == 0x2000 is a flush request. It finishes with status 1, makes no memory access and changes no register.
- R3: For any other word, bits 15:13 choose the form. Values 0 and 2 are register moves and value 3 is the status-register form. Any other value finishes with status 2 (unknown), makes no access and changes nothing.
- R4: In a register-move form, bit 9 set (MMU to memory) finishes with status 1, makes no access and changes nothing.
- R5: In a register-move form with bit 9 clear and bits 12:10 = 0, the block reads halfwords at A and A+2. It loads the translation control word as {first, second}.
- R6: Bits 12:10 = 2 load the supervisor root pointer and bits 12:10 = 3 load the CPU root pointer. Each reads halfwords at A, A+2, A+4 and A+6, in that order. The limit word is {read0, read1} and the table address word is {read2, read3}.
- R7: Any other value of bits 12:10 in a register-move form finishes with status 2, makes no access and leaves every register unchanged.
- R8: `xlate_en` equals bit 31 of the translation control word and follows every load of that word.
- R9: In the status form with bit 9 set, the block issues one write at A carrying the current status register, and changes no register.
- R10: In the status form with bit 9 clear, the block issues one read at A and loads the status register from it.
- R11: Reset clears all registers and `xlate_en`, and returns the sequencer to idle.
- R12: Only one memory request is outstanding at a time. `mem_valid`, `mem_addr` and `mem_we` hold steady until `mem_ready` is seen, and `mem_rdata` is taken in the cycle where both are high.
- R13: `cmd_ready` is high only in idle, and a command is taken when `cmd_valid` and `cmd_ready` are both high. `done` is high for exactly one cycle. For a flagged command it comes the cycle after acceptance; otherwise it comes the cycle after the last handshake. Registers already show the new value in that cycle, and `cmd_status` gives 0 = ok, 1 = unsupported, 2 = unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_word | input | 16 | Command extension word |
| cmd_addr | input | AW | Operand address (halfword aligned) |
| cmd_ready | output | 1 | Block idle, command can be taken |
| mem_valid | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | One-cycle end-of-command pulse |
| cmd_status | output | 2 | 0 ok, 1 unsupported, 2 unknown |
| tc_reg | output | 32 | Translation control word |
| srp_limit | output | 32 | Supervisor root pointer limit word |
| srp_table | output | 32 | Supervisor root pointer table address |
| crp_limit | output | 32 | CPU root pointer limit word |
| crp_table | output | 32 | CPU root pointer table address |
| mmu_status | output | 16 | MMU status register |
| xlate_en | output | 1 | Translation enable |

## Verification
A flagged command makes its `done` pulse visible one cycle after the accepting edge. An access command makes it visible one cycle after the edge of its last handshake, and the register outputs have changed by that same cycle. The bench drives on falling edges and samples one time unit after each falling edge. On the sample where `done` is first seen, it requires the memory model's handshake count to already equal the expected beat count. It also requires `done` to be low again on the next sample. The memory model stretches each request by zero to two cycles. For every beat it checks the request address, the direction and any write data in the cycle the request first appears.

// File: rtl/mmu_ld_pkg.sv
package mmu_ld_pkg;

    typedef enum logic [2:0] {
        OP_TC      = 3'd0,
        OP_SRP     = 3'd1,
        OP_CRP     = 3'd2,
        OP_MSR_LD  = 3'd3,
        OP_MSR_ST  = 3'd4,
        OP_UNSUP   = 3'd5,
        OP_UNKNOWN = 3'd6
    } ld_op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_UNSUP   = 2'd1,
        ST_UNKNOWN = 2'd2
    } ld_stat_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_READ   = 2'd1,
        S_WRITE  = 2'd2,
        S_FINISH = 2'd3
    } ld_state_e;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    function automatic ld_stat_e stat_of(ld_op_e op);
        unique case (op)
            OP_UNSUP:   return ST_UNSUP;
            OP_UNKNOWN: return ST_UNKNOWN;
            default:    return ST_OK;
        endcase
    endfunction

endpackage

// File: rtl/mmu_cmd_decode.sv
module mmu_cmd_decode
    import mmu_ld_pkg::*;
(
    input  logic [15:0] cmd_word,
    output ld_op_e      op,
    output logic [2:0]  beats
);
    logic [2:0] form;
    logic [2:0] sel;
    logic       to_mem;
    logic       is_load_entry;
    logic       is_flush;
    logic       unused_low;

    assign form          = cmd_word[15:13];
    assign sel           = cmd_word[12:10];
    assign to_mem        = cmd_word[9];
    assign is_load_entry = (cmd_word & 16'hFDE0) == 16'h2000;
    assign is_flush      = (cmd_word & 16'hE200) == 16'h2000;
    assign unused_low    = ^cmd_word[4:0];

    always_comb begin
        op = OP_UNKNOWN;
        if (is_load_entry || is_flush) begin
            op = OP_UNSUP;
        end else begin
            unique case (form)
                3'd0, 3'd2: begin
                    if (to_mem) begin
                        op = OP_UNSUP;
                    end else begin
                        unique case (sel)
                            3'd0:    op = OP_TC;
                            3'd2:    op = OP_SRP;
                            3'd3:    op = OP_CRP;
                            default: op = OP_UNKNOWN;
                        endcase
                    end
                end
                3'd3:    op = to_mem ? OP_MSR_ST : OP_MSR_LD;
                default: op = OP_UNKNOWN;
            endcase
        end
    end

    always_comb begin
        unique case (op)
            OP_TC:                beats = 3'd2;
            OP_SRP, OP_CRP:       beats = 3'd4;
            OP_MSR_LD, OP_MSR_ST: beats = 3'd1;
            default:              beats = 3'd0;
        endcase
    end

endmodule

// File: rtl/mmu_ld_seq.sv
module mmu_ld_seq
    import mmu_ld_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_addr,
    input  ld_op_e        dec_op,
    input  logic [2:0]    dec_beats,
    input  logic          mem_ready,
    output logic          cmd_ready,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic [1:0]    cmd_status,
    output ld_op_e        cur_op,
    output logic          rd_fire,
    output logic          rd_last
);
    ld_state_e     state_q, state_d;
    ld_op_e        op_q;
    ld_stat_e      stat_q;
    logic [AW-1:0] base_q;
    logic [2:0]    idx_q;
    logic [2:0]    beats_q;
    logic          accept;
    logic          at_last;

    assign accept  = (state_q == S_IDLE) && cmd_valid;
    assign at_last = (idx_q == beats_q - 3'd1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (dec_op)
                        OP_TC, OP_SRP, OP_CRP, OP_MSR_LD: state_d = S_READ;
                        OP_MSR_ST:                        state_d = S_WRITE;
                        default:                          state_d = S_FINISH;
                    endcase
                end
            end
            S_READ:   if (mem_ready && at_last) state_d = S_FINISH;
            S_WRITE:  if (mem_ready) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_UNKNOWN;
            stat_q  <= ST_OK;
            base_q  <= '0;
            idx_q   <= '0;
            beats_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q    <= dec_op;
                stat_q  <= stat_of(dec_op);
                base_q  <= cmd_addr;
                idx_q   <= '0;
                beats_q <= dec_beats;
            end else if (rd_fire) begin
                idx_q <= idx_q + 3'd1;
            end
        end
    end

    always_comb begin
        cmd_ready  = (state_q == S_IDLE);
        mem_valid  = (state_q == S_READ) || (state_q == S_WRITE);
        mem_we     = (state_q == S_WRITE);
        mem_addr   = base_q + (AW'(idx_q) << 1);
        done       = (state_q == S_FINISH);
        cmd_status = stat_q;
        cur_op     = op_q;
        rd_fire    = (state_q == S_READ) && mem_ready;
        rd_last    = rd_fire && at_last;
    end

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_no_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_valid);

    p_flag_no_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_status != 2'd0) |-> $past(cmd_ready));

endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
    import mmu_ld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ld_op_e            cur_op,
    input  logic              rd_fire,
    input  logic              rd_last,
    input  logic [HALF_W-1:0] rd_data,
    output logic [WORD_W-1:0] tc_q,
    output logic [WORD_W-1:0] srp_lim_q,
    output logic [WORD_W-1:0] srp_tab_q,
    output logic [WORD_W-1:0] crp_lim_q,
    output logic [WORD_W-1:0] crp_tab_q,
    output logic [HALF_W-1:0] msr_q,
    output logic              xen_q
);
    localparam int SH_W = 3 * HALF_W;

    logic [SH_W-1:0]     shift_q;
    logic [2*WORD_W-1:0] image;

    assign image = {shift_q, rd_data};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q   <= '0;
            tc_q      <= '0;
            srp_lim_q <= '0;
            srp_tab_q <= '0;
            crp_lim_q <= '0;
            crp_tab_q <= '0;
            msr_q     <= '0;
            xen_q     <= 1'b0;
        end else if (rd_last) begin
            shift_q <= '0;
            unique case (cur_op)
                OP_TC: begin
                    tc_q  <= image[WORD_W-1:0];
                    xen_q <= image[WORD_W-1];
                end
                OP_SRP: begin
                    srp_lim_q <= image[2*WORD_W-1:WORD_W];
                    srp_tab_q <= image[WORD_W-1:0];
                end
                OP_CRP: begin
                    crp_lim_q <= image[2*WORD_W-1:WORD_W];
                    crp_tab_q <= image[WORD_W-1:0];
                end
                OP_MSR_LD: msr_q <= rd_data;
                default: ;
            endcase
        end else if (rd_fire) begin
            shift_q <= {shift_q[SH_W-HALF_W-1:0], rd_data};
        end
    end

    p_xen_tracks_tc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xen_q == tc_q[WORD_W-1]);

    p_regs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_last |=> ($stable(tc_q) && $stable(srp_lim_q) && $stable(srp_tab_q)
                      && $stable(crp_lim_q) && $stable(crp_tab_q) && $stable(msr_q)));

endmodule

// File: rtl/mmu_ctl_loader.sv
module mmu_ctl_loader
    import mmu_ld_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [15:0]   cmd_word,
    input  logic [AW-1:0] cmd_addr,
    output logic          cmd_ready,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic [15:0]   mem_rdata,
    output logic          done,
    output logic [1:0]    cmd_status,
    output logic [31:0]   tc_reg,
    output logic [31:0]   srp_limit,
    output logic [31:0]   srp_table,
    output logic [31:0]   crp_limit,
    output logic [31:0]   crp_table,
    output logic [15:0]   mmu_status,
    output logic          xlate_en
);
    ld_op_e     dec_op;
    logic [2:0] dec_beats;
    ld_op_e     cur_op;
    logic       rd_fire;
    logic       rd_last;

    mmu_cmd_decode u_dec (
        .cmd_word (cmd_word),
        .op       (dec_op),
        .beats    (dec_beats)
    );

    mmu_ld_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_addr   (cmd_addr),
        .dec_op     (dec_op),
        .dec_beats  (dec_beats),
        .mem_ready  (mem_ready),
        .cmd_ready  (cmd_ready),
        .mem_valid  (mem_valid),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .done       (done),
        .cmd_status (cmd_status),
        .cur_op     (cur_op),
        .rd_fire    (rd_fire),
        .rd_last    (rd_last)
    );

    mmu_reg_bank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_op    (cur_op),
        .rd_fire   (rd_fire),
        .rd_last   (rd_last),
        .rd_data   (mem_rdata),
        .tc_q      (tc_reg),
        .srp_lim_q (srp_limit),
        .srp_tab_q (srp_table),
        .crp_lim_q (crp_limit),
        .crp_tab_q (crp_table),
        .msr_q     (mmu_status),
        .xen_q     (xlate_en)
    );

    assign mem_wdata = mmu_status;

    p_store_keeps_msr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |=> $stable(mmu_status));

endmodule

// File: tb/sim_mmu_ctl_loader.sv
`timescale 1ns/1ps
module sim_mmu_ctl_loader;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [15:0]   cmd_word = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_ready, mem_valid, mem_we, done, xlate_en;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata, mmu_status;
    logic          mem_ready = 1'b0;
    logic [15:0]   mem_rdata = '0;
    logic [1:0]    cmd_status;
    logic [31:0]   tc_reg, srp_limit, srp_table, crp_limit, crp_table;

    always #5 clk = ~clk;

    mmu_ctl_loader #(.AW(AW)) u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // expected model state
    logic [31:0] e_tc, e_sl, e_st, e_cl, e_ct;
    logic [15:0] e_msr;
    logic [15:0] mem_xor = '0;
    logic [31:0] x_base = '0;
    int          x_beats = 0;
    logic        x_we = 1'b0;
    int          hs_cnt = 0;
    int          wait_cnt = 0;

    function automatic logic [15:0] mdat(input logic [31:0] a, input logic [15:0] x);
        logic [15:0] p;
        p = a[15:0] * 16'h2F1B;
        return p ^ a[31:16] ^ x;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: check request, answer after 0..2 idle cycles
    always @(negedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_bad++;
            $display("FAIL watchdog R13 actual=%0d expected=%0d", cyc, 200000);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
        if (mem_ready) begin
            mem_ready = 1'b0;
            hs_cnt++;
        end else if (mem_valid) begin
            if (wait_cnt > 0) begin
                wait_cnt--;
            end else begin
                chk("R12 addr", 64'(mem_addr), 64'(x_base + 32'(2 * hs_cnt)));
                chk("R12 dir", 64'(mem_we), 64'(x_we));
                chk("R12 beat range", 64'(hs_cnt < x_beats), 64'd1);
                if (mem_we) chk("R9 wdata", 64'(mem_wdata), 64'(e_msr));
                mem_rdata = mdat(mem_addr, mem_xor);
                mem_ready = 1'b1;
                wait_cnt = (hs_cnt + int'(mem_xor[1:0])) % 3;
            end
        end
    end

    task automatic check_regs(input string req);
        chk({req, " tc"}, 64'(tc_reg), 64'(e_tc));
        chk({req, " srp"}, {srp_limit, srp_table}, {e_sl, e_st});
        chk({req, " crp"}, {crp_limit, crp_table}, {e_cl, e_ct});
        chk({req, " msr"}, 64'(mmu_status), 64'(e_msr));
        chk("R8 xlate", 64'(xlate_en), 64'(e_tc[31]));
    endtask

    // classification per R1..R4, R7: 0 tc,1 srp,2 crp,3 msr load,4 msr store,5 unsup,6 unknown
    function automatic int classify(input logic [15:0] w);
        if ((w & 16'hFDE0) == 16'h2000) return 5;
        if ((w & 16'hE200) == 16'h2000) return 5;
        if (w[15:13] == 3'd0 || w[15:13] == 3'd2) begin
            if (w[9]) return 5;
            if (w[12:10] == 3'd0) return 0;
            if (w[12:10] == 3'd2) return 1;
            if (w[12:10] == 3'd3) return 2;
            return 6;
        end
        if (w[15:13] == 3'd3) return w[9] ? 4 : 3;
        return 6;
    endfunction

    task automatic run_cmd(input logic [15:0] w, input logic [31:0] base, input logic [15:0] xr);
        int k;
        int tmo;
        logic [15:0] h[4];
        string rq;
        k = classify(w);
        rq = (k == 0) ? "R5" : (k == 1 || k == 2) ? "R6" : (k == 3) ? "R10" :
             (k == 4) ? "R9" : (w[15:13] == 3'd1) ? "R2" : (w[15:13] == 3'd0 || w[15:13] == 3'd2) ?
             ((k == 5) ? "R4" : "R7") : "R3";
        if ((w & 16'hFDE0) == 16'h2000) rq = "R1";
        mem_xor = xr;
        x_base = base;
        x_we = (k == 4);
        x_beats = (k == 0) ? 2 : (k == 1 || k == 2) ? 4 : (k == 3 || k == 4) ? 1 : 0;
        hs_cnt = 0;
        wait_cnt = int'(xr[3:2]) % 3;
        for (int i = 0; i < 4; i++) h[i] = mdat(base + 32'(2 * i), xr);
        chk("R13 ready", 64'(cmd_ready), 64'd1);
        cmd_word = w;
        cmd_addr = base;
        cmd_valid = 1'b1;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        tmo = 0;
        while (!done && tmo < 60) begin
            @(negedge clk); #1;
            tmo++;
        end
        chk({rq, " done seen"}, 64'(done), 64'd1);
        if (x_beats == 0) chk({rq, " flag latency"}, 64'(tmo), 64'd0);
        chk({rq, " beats at done"}, 64'(hs_cnt), 64'(x_beats));
        chk({rq, " status"}, 64'(cmd_status), (k == 5) ? 64'd1 : (k == 6) ? 64'd2 : 64'd0);
        case (k)
            0: e_tc = {h[0], h[1]};
            1: begin e_sl = {h[0], h[1]}; e_st = {h[2], h[3]}; end
            2: begin e_cl = {h[0], h[1]}; e_ct = {h[2], h[3]}; end
            3: e_msr = h[0];
            default: ;
        endcase
        check_regs(rq);
        @(negedge clk); #1;
        chk("R13 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        rst_n = 1'b1;
        e_tc = '0; e_sl = '0; e_st = '0; e_cl = '0; e_ct = '0; e_msr = '0;
    endtask

    initial begin
        logic [15:0] xr;
        bit seen_on, seen_off;
        seen_on = 0;
        seen_off = 0;
        do_reset();
        check_regs("R11 reset");
        chk("R11 idle", 64'(cmd_ready), 64'd1);
        // directed: a TC image with bit 31 set and one with it clear
        xr = 16'h0000;
        for (int t = 0; t < 64 && !(seen_on && seen_off); t++) begin
            xr = 16'(t * 16'h1357);
            run_cmd(16'h0000, 32'h0000_4000 + 32'(t * 4), xr);
            if (xlate_en) seen_on = 1; else seen_off = 1;
        end
        chk("R8 both enable states", 64'({seen_on, seen_off}), 64'b11);
        // directed corners
        run_cmd(16'h6000, 32'h0000_8000, 16'h0F0F);   // R10 load status
        run_cmd(16'h6200, 32'h0000_9000, 16'h0000);   // R9 store status
        run_cmd(16'h2200, 32'h0000_A000, 16'h0000);   // R1 load-entry, bit 9 set
        run_cmd(16'h2600, 32'h0000_A000, 16'h0000);   // R3 form 1, not load/flush
        run_cmd(16'h2400, 32'h0000_A000, 16'h0000);   // R2 flush
        run_cmd(16'h0800, 32'h0000_B000, 16'h3C3C);   // R6 supervisor pointer
        run_cmd(16'h4C00, 32'h0000_C000, 16'h5A5A);   // R6 CPU pointer, form 2
        run_cmd(16'h1000, 32'h0000_D000, 16'h0000);   // R7 select 4
        run_cmd(16'h0200, 32'h0000_D000, 16'h0000);   // R4 to-memory direction
        // sweep bits 15:5 with varied low bits
        for (int i = 0; i < 2048; i++) begin
            logic [15:0] w;
            logic [31:0] b;
            w = {11'(i), 5'((i * 7) % 32)};
            b = (32'(i) * 32'h9E37_79B1) & 32'hFFFF_FFF0;
            run_cmd(w, b, 16'(i * 16'h0061 + 16'h0123));
        end
        // R11: reset with translation on
        for (int t = 0; t < 64 && !xlate_en; t++) run_cmd(16'h0000, 32'h100, 16'(t * 16'h0777));
        chk("R11 precondition enable", 64'(xlate_en), 64'd1);
        do_reset();
        check_regs("R11 reset after load");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule